// File: doc/BRIEF.md
# Guarded Configuration Register with Unlock Handshake

The block holds one byte of physical-layer and bus-option configuration that shares a single register address with the high byte of a remote byte count. A read of that address always returns the configuration byte. A write reaches the configuration byte only when the access directly before it was a read of the same address. Any other write to the address, including one made after an intervening access, lands in the byte-count register. This protects the configuration against stray writes.

Not every configuration bit is plain storage. The bus-error flag is set by a hardware event and cleared by writing a one to it. The link bit is written as a "disable link testing" control but reads back as live link status. The EEPROM-load bit fires a one-clock start pulse and then reads as zero.

The unlock sequencing is a two-state machine. In `ST_LOCKED` the guard is shut. In `ST_ARMED` the next write to the shared address is accepted. It has these transitions:
- `T_ARM`: a read (without a write) of the shared address moves `ST_LOCKED` to `ST_ARMED`. It also keeps `ST_ARMED` in `ST_ARMED`.
- `T_CONSUME`: a write of any address moves `ST_ARMED` to `ST_LOCKED`.
- `T_BREAK`: a read of any other address moves `ST_ARMED` to `ST_LOCKED`.
- `T_HOLD`: a cycle with no access leaves the state unchanged.

Top module: `cfg_guard_reg`

## Requirements
- R1: After reset every stored bit is 0. The outputs are then: `phy_mode_o`=00, `link_test_dis_o`=0, `thin_en_o`=0, `prom_wr_en_o`=0, `io16_after_cmd_o`=0, `chrdy_from_ale_o`=0, `ee_load_start_o`=0 and `rbc_hi_o`=0x00.
- R2: While `rd_en` is high with `addr`=0xB, `rdata` shows the configuration view in the same cycle, whatever the unlock state. The view is: [1:0] mode, [2] live link, [3] io16 option, [4] chrdy option, [5] bus-error flag, [6] PROM write enable, [7] load pending. In every other case `rdata` is 0x00.
- R3: A write to 0xB in the cycle that follows a read of 0xB updates the configuration at the clock edge and leaves `rbc_hi_o` unchanged. Cycles with no access between the read and the write do not break the unlock.
- R4: A write to 0xB that does not directly follow a read of 0xB stores `wdata` into `rbc_hi_o` and leaves the configuration unchanged.
- R5: Any write, or any read of another address, locks the guard again. So two guarded writes need two reads.
- R6: `phy_mode_o` carries bits [1:0]. The codes are: 00 twisted pair with standard squelch, 01 thin coax, 10 thick coax, 11 twisted pair with reduced squelch. `thin_en_o` is 1 only for code 01.
- R7: Written bit 2 drives `link_test_dis_o`. Read bit 2 is 1 when the mode is twisted pair (00 or 11) and either link testing is disabled or `link_good_i` is 1. In the thin-coax and thick-coax modes (01 and 10) it reads 0.
- R8: `bus_err_evt_i` sets bit 5. A guarded write with bit 5 = 1 clears it. A guarded write with bit 5 = 0 leaves it unchanged.
- R9: When a bus-error event and a clearing write fall in the same cycle, bit 5 stays 1.
- R10: Bits 3, 4 and 6 drive `io16_after_cmd_o`, `chrdy_from_ale_o` and `prom_wr_en_o`.
- R11: A guarded write with bit 7 = 1 raises `ee_load_start_o` for exactly the one cycle after the write. Bit 7 reads 1 only in that cycle and reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| link_good_i | input | 1 | Link integrity good, from the physical layer |
| bus_err_evt_i | input | 1 | One-cycle bus-error event |
| phy_mode_o | output | 2 | Physical interface select |
| thin_en_o | output | 1 | Thin-coax converter enable |
| link_test_dis_o | output | 1 | Disable link pulses and integrity check |
| io16_after_cmd_o | output | 1 | 16-bit indication follows the command strobe |
| chrdy_from_ale_o | output | 1 | Channel-ready follows the address latch strobe |
| prom_wr_en_o | output | 1 | Allow boot PROM write cycles |
| ee_load_start_o | output | 1 | One-clock EEPROM load start |
| rbc_hi_o | output | 8 | Remote byte count high byte |

## Verification
A bus-error event can fall in the same cycle as a guarded write that clears bit 5. A guarded write can also fall in the same cycle as the re-locking of the guard. The bench causes the first case by raising `bus_err_evt_i` together with a write of 0x20 after an unlock read. It causes the second by issuing two writes back to back after a single read. A behavioural model is compared with `rdata` and every output on every cycle. It expects the flag to survive the collision and the second write to land in the byte-count register.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_ARMED  = 1'b1
    } guard_state_t;

    // bit positions of the configuration view
    localparam int B_MODE_LO = 0;
    localparam int B_MODE_HI = 1;
    localparam int B_LINK    = 2;
    localparam int B_IO16    = 3;
    localparam int B_CHRDY   = 4;
    localparam int B_BUSERR  = 5;
    localparam int B_PROMWR  = 6;
    localparam int B_EELOAD  = 7;
    localparam int CFG_W     = 8;

    localparam logic [1:0] MODE_TP_STD  = 2'b00;
    localparam logic [1:0] MODE_THIN    = 2'b01;
    localparam logic [1:0] MODE_THICK   = 2'b10;
    localparam logic [1:0] MODE_TP_LONG = 2'b11;
endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
    import cfg_guard_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 4'hB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic              cfg_we,
    output logic              rbc_we
);
    guard_state_t state_q, state_d;
    logic hit;

    assign hit = (addr == CFG_ADDR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cfg_we  = 1'b0;
        rbc_we  = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                if (wr_en) begin
                    rbc_we = hit;
                end else if (rd_en && hit) begin
                    state_d = ST_ARMED;                // T_ARM
                end
            end
            ST_ARMED: begin
                if (wr_en) begin
                    cfg_we  = hit;
                    rbc_we  = 1'b0;
                    state_d = ST_LOCKED;               // T_CONSUME
                end else if (rd_en && !hit) begin
                    state_d = ST_LOCKED;               // T_BREAK
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // R5: any write leaves the guard locked
    p_relock_after_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state_q == ST_LOCKED);
    // R3: a read of the shared address arms the guard
    p_arm_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && hit) |=> state_q == ST_ARMED);
    // R4: the two destinations never both take a write
    p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && rbc_we));
endmodule

// File: rtl/cfg_fields.sv
module cfg_fields
    import cfg_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             rbc_we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             link_good_i,
    input  logic             bus_err_evt_i,
    output logic [CFG_W-1:0] cfg_view,
    output logic [1:0]       mode_q,
    output logic             link_dis_q,
    output logic             io16_q,
    output logic             chrdy_q,
    output logic             prom_q,
    output logic             ee_pulse_q,
    output logic [CFG_W-1:0] rbc_q
);
    logic be_q;
    logic twisted;
    logic link_live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_TP_STD;
            link_dis_q <= 1'b0;
            io16_q     <= 1'b0;
            chrdy_q    <= 1'b0;
            prom_q     <= 1'b0;
            be_q       <= 1'b0;
            ee_pulse_q <= 1'b0;
            rbc_q      <= '0;
        end else begin
            if (cfg_we) begin
                mode_q     <= wdata[B_MODE_HI:B_MODE_LO];
                link_dis_q <= wdata[B_LINK];
                io16_q     <= wdata[B_IO16];
                chrdy_q    <= wdata[B_CHRDY];
                prom_q     <= wdata[B_PROMWR];
            end
            // event wins over a same-cycle clear
            be_q       <= (be_q & ~(cfg_we & wdata[B_BUSERR])) | bus_err_evt_i;
            ee_pulse_q <= cfg_we & wdata[B_EELOAD];
            if (rbc_we) rbc_q <= wdata;
        end
    end

    assign twisted   = (mode_q == MODE_TP_STD) || (mode_q == MODE_TP_LONG);
    assign link_live = twisted & (link_dis_q | link_good_i);

    always_comb begin
        cfg_view                       = '0;
        cfg_view[B_MODE_HI:B_MODE_LO]  = mode_q;
        cfg_view[B_LINK]               = link_live;
        cfg_view[B_IO16]               = io16_q;
        cfg_view[B_CHRDY]              = chrdy_q;
        cfg_view[B_BUSERR]             = be_q;
        cfg_view[B_PROMWR]             = prom_q;
        cfg_view[B_EELOAD]             = ee_pulse_q;
    end

    // R9: an event always leaves the flag set
    p_event_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_evt_i |=> be_q);
    // R8: a guarded write with bit 5 clear keeps a set flag
    p_zero_write_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (be_q && cfg_we && !wdata[B_BUSERR]) |=> be_q);
    // R11: load start lasts one cycle
    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ee_pulse_q |=> !ee_pulse_q);
    // R4: byte count moves only on its own write
    p_rbc_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rbc_we |=> $stable(rbc_q));
endmodule

// File: rtl/cfg_guard_reg.sv
module cfg_guard_reg
    import cfg_guard_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 4'hB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              link_good_i,
    input  logic              bus_err_evt_i,
    output logic [1:0]        phy_mode_o,
    output logic              thin_en_o,
    output logic              link_test_dis_o,
    output logic              io16_after_cmd_o,
    output logic              chrdy_from_ale_o,
    output logic              prom_wr_en_o,
    output logic              ee_load_start_o,
    output logic [7:0]        rbc_hi_o
);
    logic             cfg_we, rbc_we;
    logic [CFG_W-1:0] cfg_view;

    cfg_unlock_fsm #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .cfg_we (cfg_we),
        .rbc_we (rbc_we)
    );

    cfg_fields u_fields (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .rbc_we        (rbc_we),
        .wdata         (wdata),
        .link_good_i   (link_good_i),
        .bus_err_evt_i (bus_err_evt_i),
        .cfg_view      (cfg_view),
        .mode_q        (phy_mode_o),
        .link_dis_q    (link_test_dis_o),
        .io16_q        (io16_after_cmd_o),
        .chrdy_q       (chrdy_from_ale_o),
        .prom_q        (prom_wr_en_o),
        .ee_pulse_q    (ee_load_start_o),
        .rbc_q         (rbc_hi_o)
    );

    assign thin_en_o = (phy_mode_o == MODE_THIN);
    assign rdata     = (rd_en && addr == CFG_ADDR) ? cfg_view : 8'h00;

    // R6: converter enable never set in a twisted-pair or thick mode
    p_thin_only_coax_r6: assert property (@(posedge clk) disable iff (!rst_n)
        thin_en_o |-> (phy_mode_o != MODE_TP_STD && phy_mode_o != MODE_THICK
                       && phy_mode_o != MODE_TP_LONG));
    // R7: live link bit never reads 1 in a coax mode
    p_link_coax_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CFG_ADDR && (phy_mode_o == MODE_THIN || phy_mode_o == MODE_THICK))
            |-> !rdata[B_LINK]);
endmodule

// File: tb/cfg_guard_reg_test.sv
module cfg_guard_reg_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_CFG = 4'hB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       link_good_i = 1'b0, bus_err_evt_i = 1'b0;
    logic [1:0] phy_mode_o;
    logic       thin_en_o, link_test_dis_o, io16_after_cmd_o, chrdy_from_ale_o;
    logic       prom_wr_en_o, ee_load_start_o;
    logic [7:0] rbc_hi_o;

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state
    logic [1:0] m_mode;
    bit m_ldis, m_io16, m_chrdy, m_be, m_prom, m_ee, m_armed;
    logic [7:0] m_rbc;

    cfg_guard_reg uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .link_good_i(link_good_i),
        .bus_err_evt_i(bus_err_evt_i), .phy_mode_o(phy_mode_o),
        .thin_en_o(thin_en_o), .link_test_dis_o(link_test_dis_o),
        .io16_after_cmd_o(io16_after_cmd_o), .chrdy_from_ale_o(chrdy_from_ale_o),
        .prom_wr_en_o(prom_wr_en_o), .ee_load_start_o(ee_load_start_o),
        .rbc_hi_o(rbc_hi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode = 2'b00; m_ldis = 0; m_io16 = 0; m_chrdy = 0; m_be = 0;
        m_prom = 0; m_ee = 0; m_armed = 0; m_rbc = 8'h00;
    endtask

    function automatic logic [7:0] exp_rdata();
        bit tp, live;
        tp = (m_mode == 2'b00) || (m_mode == 2'b11);
        live = tp && (m_ldis || link_good_i);
        if (rd_en && addr == A_CFG)
            return {m_ee, m_prom, m_be, m_chrdy, m_io16, live, m_mode};
        return 8'h00;
    endfunction

    task automatic compare_all();
        chk("R2 rdata", rdata, exp_rdata());
        chk("R6 phy_mode", phy_mode_o, m_mode);
        chk("R6 thin_en", thin_en_o, (m_mode == 2'b01));
        chk("R7 link_test_dis", link_test_dis_o, m_ldis);
        chk("R10 io16", io16_after_cmd_o, m_io16);
        chk("R10 chrdy", chrdy_from_ale_o, m_chrdy);
        chk("R10 prom", prom_wr_en_o, m_prom);
        chk("R11 ee_start", ee_load_start_o, m_ee);
        chk("R3 R4 rbc_hi", rbc_hi_o, m_rbc);
    endtask

    // one bus cycle: drive at negedge, compare, advance model at posedge
    task automatic cyc(bit rd, bit wr, logic [3:0] a, logic [7:0] d, bit lnk, bit evt);
        bit hit;
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wdata = d;
        link_good_i = lnk; bus_err_evt_i = evt;
        #1;
        compare_all();
        hit = (a == A_CFG);
        @(posedge clk);
        if (wr && hit && m_armed) begin
            m_mode = d[1:0]; m_ldis = d[2]; m_io16 = d[3]; m_chrdy = d[4];
            m_prom = d[6];
            m_be = (m_be && !d[5]) || evt;
            m_ee = d[7];
        end else begin
            if (wr && hit) m_rbc = d;
            m_be = m_be || evt;
            m_ee = 0;
        end
        if (wr) m_armed = 0;
        else if (rd && hit) m_armed = 1;
        else if (rd) m_armed = 0;
    endtask

    task automatic idle(bit lnk); cyc(0, 0, 4'h0, 8'h00, lnk, 0); endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 phy_mode", phy_mode_o, 0);
        chk("R1 rbc_hi", rbc_hi_o, 0);
        chk("R1 ee_start", ee_load_start_o, 0);
        chk("R1 prom", prom_wr_en_o, 0);
        chk("R1 link_dis", link_test_dis_o, 0);
        cyc(1, 0, A_CFG, 0, 1, 0);          // R2 view after reset, link good
        // R4: write without unlock
        cyc(0, 1, A_CFG, 8'h5A, 1, 0);
        cyc(1, 0, A_CFG, 0, 1, 0);
        // R3: unlock then write
        cyc(0, 1, A_CFG, 8'h59, 1, 0);
        cyc(1, 0, A_CFG, 0, 0, 0);
        // R3: idle gap keeps unlock
        cyc(1, 0, A_CFG, 0, 0, 0);
        idle(0); idle(0);
        cyc(0, 1, A_CFG, 8'h4B, 0, 0);
        cyc(1, 0, A_CFG, 0, 0, 0);
        // R5: read of another address breaks unlock
        cyc(1, 0, A_CFG, 0, 0, 0);
        cyc(1, 0, 4'h3, 0, 0, 0);
        cyc(0, 1, A_CFG, 8'h77, 0, 0);
        // R5: write elsewhere breaks unlock
        cyc(1, 0, A_CFG, 0, 0, 0);
        cyc(0, 1, 4'h2, 8'h11, 0, 0);
        cyc(0, 1, A_CFG, 8'h22, 0, 0);
        // R5: back-to-back writes after one read
        cyc(1, 0, A_CFG, 0, 0, 0);
        cyc(0, 1, A_CFG, 8'h40, 0, 0);
        cyc(0, 1, A_CFG, 8'h33, 0, 0);
        // R6 R7: every mode with link and disable combinations
        for (int m = 0; m < 4; m++) begin
            for (int dis = 0; dis < 2; dis++) begin
                cyc(1, 0, A_CFG, 0, 0, 0);
                cyc(0, 1, A_CFG, 8'((dis << 2) | m), 0, 0);
                cyc(1, 0, A_CFG, 0, 0, 0);
                cyc(1, 0, A_CFG, 0, 1, 0);
            end
        end
        // R8: event sets, zero write keeps, one write clears
        cyc(0, 0, 4'h0, 0, 1, 1);
        cyc(1, 0, A_CFG, 0, 1, 0);
        cyc(0, 1, A_CFG, 8'h00, 1, 0);
        cyc(1, 0, A_CFG, 0, 1, 0);
        cyc(0, 1, A_CFG, 8'h20, 1, 0);
        cyc(1, 0, A_CFG, 0, 1, 0);
        // R9: event and clear collide
        cyc(0, 1, A_CFG, 8'h20, 1, 1);
        cyc(1, 0, A_CFG, 0, 1, 0);
        cyc(0, 1, A_CFG, 8'h20, 1, 1);
        cyc(1, 0, A_CFG, 0, 1, 0);
        // R11: load pulse then reads zero; R10 bits 3,4,6
        cyc(0, 1, A_CFG, 8'hD8, 1, 0);
        cyc(1, 0, A_CFG, 0, 1, 0);
        cyc(1, 0, A_CFG, 0, 1, 0);
        idle(1);
        cyc(1, 0, A_CFG, 0, 1, 0);
        cyc(0, 1, A_CFG, 8'h80, 1, 0);
        idle(1); idle(1);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule